// File: doc/BRIEF.md
# Real-Time Clock Register File with Periodic Interrupt

This block is the register side of a real-time clock, reached by software through two byte-wide ports: an index port that selects one of fourteen locations, and a data port that reads or writes the selected location. Locations 0 to 9 hold the time-of-day bytes. They are plain storage that reset loads from parameters in binary, 24-hour form. Locations 10 and 11 are two status/control registers. Locations 12 and 13 are reserved, and any access to them is an error.

Register A reports a fixed time-base and rate setting plus an update-in-progress flag, which flips on every read. Register B holds the data-format bits and a periodic-interrupt enable. While that enable is set, a timer emits a one-cycle interrupt pulse every `PERIOD_CYCLES` clock cycles. Illegal accesses do not halt anything. They set a sticky error flag that software clears with a strobe.

An access is one cycle with `acc_valid` high. `acc_port` selects the index port (0) or the data port (1), and `acc_write` selects write (1) or read (0). Read data is registered.

Top module: `rtc_regfile`

## Requirements
- R1: A write to the index port with a value 0..13 selects that location. A read of the index port returns the current index. Read data appears on `acc_rdata` in the cycle after the access edge and holds until the next read. Reset clears the index and `acc_rdata` to 0.
- R2: An index-port write with a value above 13 sets the error flag and leaves the index unchanged.
- R3: Locations 0..9 are read/write bytes. Reset loads them as follows: 0 = seconds, 2 = minutes, 4 = hours, 6 = weekday, 7 = day of month, 8 = month, 9 = year. Locations 1, 3 and 5 reset to 0.
- R4: Location 6 resets to the 0-based weekday parameter plus one.
- R5: Register A (location 10) resets to 0x26. Bit 7 is the update-in-progress flag. Each read of register A inverts bit 7 first and returns the new value, so the first read after reset returns 0xA6.
- R6: A write of 0x26 to register A is accepted without change. A write of any other value sets the error flag, and register A keeps its value.
- R7: Register B (location 11) resets to 0x46. A write is stored only if (data & 0xB7) == 0x06, meaning only bit 6 (periodic enable) and bit 3 (square-wave enable) may vary. Any other write sets the error flag and leaves B unchanged.
- R8: Setting B bit 6 from 0 starts the timer, with the first pulse `PERIOD_CYCLES` cycles after the write edge. Rewriting the bit while it is already 1 does not restart the timer. Clearing the bit stops the timer, and no pulse follows the disabling edge.
- R9: While enabled, `irq_pulse` is high for exactly one cycle every `PERIOD_CYCLES` cycles. After reset the timer runs at once.
- R10: A read or write of location 12 or 13 sets the error flag. Such a read returns 0x00.
- R11: The error flag stays set until `err_clr`. If an error and `err_clr` fall in the same cycle, the flag ends up set.
- R12: If a write that clears B bit 6 lands on the same edge as a timer expiry, that pulse is still emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| irq_pulse | output | 1 | One-cycle periodic interrupt |
| err_flag | output | 1 | Sticky illegal-access flag |
| err_clr | input | 1 | Clears the error flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a write to register B that clears the periodic enable and a timer expiry. The bench locks onto one pulse, idles exactly one period less one cycle, and then issues the disabling write so that its edge is the expiry edge. It expects the pulse at that edge and silence for several periods afterwards. The second pair is an illegal access and `err_clr` in the same cycle; that case is judged by the flag staying set. A behavioural model in the bench, updated per clock, predicts read data, pulse and flag on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW          = 8;
  localparam int IDX_W       = 4;
  localparam int TIME_BYTES  = 10;
  localparam int LOC_A       = 10;
  localparam int LOC_B       = 11;
  localparam int LOC_LAST    = 13;

  localparam logic [DW-1:0] A_RESET  = 8'h26;  // 32.768 kHz base, 1024 Hz rate
  localparam logic [DW-1:0] A_UIP    = 8'h80;
  localparam logic [DW-1:0] B_PIE    = 8'h40;
  localparam logic [DW-1:0] B_SQW    = 8'h08;
  localparam logic [DW-1:0] B_FIXED  = 8'h06;  // binary format, 24-hour
  localparam logic [DW-1:0] B_RESET  = B_FIXED | B_PIE;

  typedef enum logic [1:0] {
    TGT_TIME,
    TGT_A,
    TGT_B,
    TGT_RSVD
  } tgt_e;
endpackage

// File: rtl/rtc_time_store.sv
module rtc_time_store #(
  parameter int BYTES = 10,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter logic [DW*BYTES-1:0] INIT_IMAGE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= INIT_IMAGE[g*DW +: DW];
      else if (we && addr == AW'(g))
        mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < BYTES; i++)
      if (addr == AW'(i)) rdata = mem[i];
  end
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          a_read,
  input  logic          b_write,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rega,
  output logic [DW-1:0] regb,
  output logic          b_reject
);
  logic [DW-1:0] b_masked;

  always_comb begin
    b_masked = wdata & ~(B_PIE | B_SQW);
    b_reject = (b_masked != B_FIXED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rega <= A_RESET;
      regb <= B_RESET;
    end else begin
      if (a_read)
        rega <= rega ^ A_UIP;
      if (b_write && !b_reject)
        regb <= wdata;
    end
  end
endmodule

// File: rtl/rtc_periodic_timer.sv
module rtc_periodic_timer #(
  parameter int PERIOD = 976
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic irq
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      irq <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int PERIOD_CYCLES = 976,
  parameter int INIT_SEC      = 0,
  parameter int INIT_MIN      = 0,
  parameter int INIT_HOUR     = 0,
  parameter int INIT_WDAY0    = 0,
  parameter int INIT_MDAY     = 1,
  parameter int INIT_MONTH    = 1,
  parameter int INIT_YEAR     = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_port,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          irq_pulse,
  output logic          err_flag,
  input  logic          err_clr
);
  localparam logic [DW*TIME_BYTES-1:0] TIME_INIT = {
    DW'(INIT_YEAR), DW'(INIT_MONTH), DW'(INIT_MDAY), DW'(INIT_WDAY0 + 1),
    DW'(0), DW'(INIT_HOUR), DW'(0), DW'(INIT_MIN), DW'(0), DW'(INIT_SEC)
  };

  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    rega_q, regb_q, time_rd;
  logic             b_reject;
  tgt_e             tgt;
  logic             idx_wr, idx_rd, dat_wr, dat_rd, err_set;

  always_comb begin
    if (idx_q < IDX_W'(TIME_BYTES))  tgt = TGT_TIME;
    else if (idx_q == IDX_W'(LOC_A)) tgt = TGT_A;
    else if (idx_q == IDX_W'(LOC_B)) tgt = TGT_B;
    else                             tgt = TGT_RSVD;
  end

  always_comb begin
    idx_wr = acc_valid &&  acc_write && !acc_port;
    idx_rd = acc_valid && !acc_write && !acc_port;
    dat_wr = acc_valid &&  acc_write &&  acc_port;
    dat_rd = acc_valid && !acc_write &&  acc_port;
    err_set = (idx_wr && acc_wdata > DW'(LOC_LAST))
           || ((dat_wr || dat_rd) && tgt == TGT_RSVD)
           || (dat_wr && tgt == TGT_A && acc_wdata != A_RESET)
           || (dat_wr && tgt == TGT_B && b_reject);
  end

  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= '0;
    else if (idx_wr && acc_wdata <= DW'(LOC_LAST))
      idx_q <= acc_wdata[IDX_W-1:0];
  end

  rtc_time_store #(
    .BYTES(TIME_BYTES), .AW(IDX_W), .DW(DW), .INIT_IMAGE(TIME_INIT)
  ) u_time (
    .clk(clk), .rst(rst),
    .we(dat_wr && tgt == TGT_TIME),
    .addr(idx_q), .wdata(acc_wdata), .rdata(time_rd)
  );

  rtc_status_regs u_stat (
    .clk(clk), .rst(rst),
    .a_read(dat_rd && tgt == TGT_A),
    .b_write(dat_wr && tgt == TGT_B),
    .wdata(acc_wdata),
    .rega(rega_q), .regb(regb_q), .b_reject(b_reject)
  );

  rtc_periodic_timer #(.PERIOD(PERIOD_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .enable(|(regb_q & B_PIE)), .irq(irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
    end else if (idx_rd) begin
      acc_rdata <= DW'(idx_q);
    end else if (dat_rd) begin
      unique case (tgt)
        TGT_TIME: acc_rdata <= time_rd;
        TGT_A:    acc_rdata <= rega_q ^ A_UIP;
        TGT_B:    acc_rdata <= regb_q;
        default:  acc_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err_flag <= 1'b0;
    else if (err_set) err_flag <= 1'b1;
    else if (err_clr) err_flag <= 1'b0;
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_write,
  input logic       acc_port,
  input logic [7:0] acc_wdata,
  input logic [3:0] idx_q,
  input logic [7:0] rega_q,
  input logic [7:0] regb_q,
  input logic       irq_pulse,
  input logic       err_flag,
  input logic       err_clr
);
  a_r1_index_range: assert property (@(posedge clk) disable iff (rst)
    idx_q <= 4'd13);

  a_r2_bad_index_kept: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && !acc_port && acc_wdata > 8'd13)
      |=> ($stable(idx_q) && err_flag));

  a_r5_uip_flips: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_port && idx_q == 4'd10)
      |=> (rega_q[7] != $past(rega_q[7])));

  a_r6_rega_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    rega_q[6:0] == 7'h26);

  a_r7_regb_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (regb_q & 8'hB7) == 8'h06);

  a_r8_no_pulse_when_off: assert property (@(posedge clk) disable iff (rst)
    !regb_q[6] |=> !irq_pulse);

  a_r9_single_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  a_r11_sticky_error: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk(clk), .rst(rst),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_port(acc_port),
  .acc_wdata(acc_wdata), .idx_q(idx_q), .rega_q(rega_q), .regb_q(regb_q),
  .irq_pulse(irq_pulse), .err_flag(err_flag), .err_clr(err_clr)
);

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int P = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_port = 1'b0, err_clr = 1'b0;
  logic [7:0] acc_wdata = '0, acc_rdata;
  logic irq_pulse, err_flag;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regfile #(
    .PERIOD_CYCLES(P), .INIT_SEC(45), .INIT_MIN(30), .INIT_HOUR(23),
    .INIT_WDAY0(6), .INIT_MDAY(31), .INIT_MONTH(12), .INIT_YEAR(99)
  ) i_rtc_regfile (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .irq_pulse(irq_pulse), .err_flag(err_flag), .err_clr(err_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, one update per clock
  int m_time[10];
  int m_idx, m_a, m_b, m_cnt, m_irq, m_err, m_rd;
  bit m_e;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_time = '{45, 0, 30, 0, 23, 0, 7, 31, 12, 99};
      m_idx = 0; m_a = 'h26; m_b = 'h46; m_cnt = 0; m_irq = 0; m_err = 0; m_rd = 0;
    end else begin
      if (m_b & 'h40) begin
        if (m_cnt == P - 1) begin m_irq = 1; m_cnt = 0; end
        else begin m_irq = 0; m_cnt++; end
      end else begin
        m_irq = 0; m_cnt = 0;
      end
      m_e = 0;
      if (acc_valid) begin
        if (!acc_port) begin
          if (acc_write) begin
            if (acc_wdata > 13) m_e = 1; else m_idx = acc_wdata;
          end else begin
            m_rd = m_idx; m_tag = "R1";
          end
        end else if (acc_write) begin
          if (m_idx < 10) m_time[m_idx] = acc_wdata;
          else if (m_idx == 10) begin if (acc_wdata != 'h26) m_e = 1; end
          else if (m_idx == 11) begin
            if ((acc_wdata & 'hB7) == 'h06) m_b = acc_wdata; else m_e = 1;
          end else m_e = 1;
        end else begin
          if (m_idx < 10) begin m_rd = m_time[m_idx]; m_tag = "R3"; end
          else if (m_idx == 10) begin m_a = m_a ^ 'h80; m_rd = m_a; m_tag = "R5"; end
          else if (m_idx == 11) begin m_rd = m_b; m_tag = "R7"; end
          else begin m_rd = 0; m_e = 1; m_tag = "R10"; end
        end
      end
      if (m_e) m_err = 1;
      else if (err_clr) m_err = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(m_tag, acc_rdata, m_rd);
      chk("R9 irq", irq_pulse, m_irq);
      chk("R11 err", err_flag, m_err);
    end
  end

  task automatic acc(input bit port, input bit wr, input logic [7:0] d);
    acc_valid = 1'b1; acc_port = port; acc_write = wr; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic clr_err();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq_pulse && n < 1000);
  endtask

  task automatic count_irq(input int cycles, output int k);
    k = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq_pulse) k++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset rdata", acc_rdata, 0);
    chk("R11 reset err", err_flag, 0);

    // R3 / R4 reset image and storage
    acc(0, 1, 8'd6); acc(1, 0, 0); chk("R4 weekday", acc_rdata, 7);
    acc(0, 1, 8'd9); acc(1, 0, 0); chk("R3 year", acc_rdata, 99);
    acc(0, 1, 8'd1); acc(1, 0, 0); chk("R3 alarm slot", acc_rdata, 0);
    acc(1, 1, 8'h55); acc(1, 0, 0); chk("R3 write back", acc_rdata, 'h55);

    // R2 out-of-range index
    acc(0, 1, 8'd14); chk("R2 err", err_flag, 1);
    acc(0, 0, 0); chk("R2 index kept", acc_rdata, 1);
    clr_err(); chk("R11 cleared", err_flag, 0);

    // R5 / R6 register A
    acc(0, 1, 8'd10);
    acc(1, 0, 0); chk("R5 first read", acc_rdata, 'hA6);
    acc(1, 0, 0); chk("R5 second read", acc_rdata, 'h26);
    acc(1, 1, 8'h26); chk("R6 legal write", err_flag, 0);
    acc(1, 1, 8'h27); chk("R6 bad write", err_flag, 1);
    acc(1, 0, 0); chk("R6 A kept", acc_rdata, 'hA6);
    // R11 error and clear in the same cycle: set wins
    err_clr = 1'b1; acc(1, 1, 8'h00); err_clr = 1'b0;
    chk("R11 set beats clear", err_flag, 1);
    clr_err();

    // R7 register B
    acc(0, 1, 8'd11);
    acc(1, 1, 8'h4E); acc(1, 0, 0); chk("R7 legal write", acc_rdata, 'h4E);
    acc(1, 1, 8'h47); chk("R7 bad write err", err_flag, 1);
    acc(1, 0, 0); chk("R7 B kept", acc_rdata, 'h4E);
    clr_err();

    // R9 interval
    gap(n); gap(n); chk("R9 interval", n, P);

    // R8 stop and restart
    acc(1, 1, 8'h06); count_irq(3*P, n); chk("R8 stopped", n, 0);
    acc(1, 1, 8'h46); gap(n); chk("R8 restart delay", n, P);

    // R12 disable on the expiry edge
    repeat (P - 1) @(negedge clk);
    acc(1, 1, 8'h06); chk("R12 pulse kept", irq_pulse, 1);
    count_irq(3*P, n); chk("R8 silent after", n, 0);

    // R10 reserved locations
    acc(0, 1, 8'd12); acc(1, 0, 0);
    chk("R10 read zero", acc_rdata, 0); chk("R10 read err", err_flag, 1);
    clr_err();
    acc(0, 1, 8'd13); acc(1, 1, 8'hFF); chk("R10 write err", err_flag, 1);
    clr_err();

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule